// File: doc/BRIEF.md
# Byte-Stuffing Frame Encoder

This block turns a stream of payload bytes into a delimited byte stream for a byte-oriented serial link. Each input beat carries one payload byte, plus markers for the first and last beat of a frame. The block puts a delimiter byte (0x7E) ahead of the first payload byte of each frame and another after the last. Any payload byte that matches either the delimiter or the escape character (0x7D) is replaced by a two-byte escape pair. All other bytes pass through unchanged.

Both sides use a valid/ready handshake. One input beat can produce up to four output bytes. The block keeps a small list of pending output items and lowers its input ready while that list holds more than the output register can drain in one cycle. A beat can carry only markers, with no payload byte. This is how an empty frame is sent.

Top module: `bstuff_encoder`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat with `in_sof`=1 causes one 0x7E byte to be emitted before any output from that beat's payload byte.
- R3: A beat with `in_eof`=1 causes one 0x7E byte to be emitted after that beat's payload output.
- R4: A payload byte 0x7E is emitted as 0x7D followed directly by 0x5E.
- R5: A payload byte 0x7D is emitted as 0x7D followed directly by 0x5D.
- R6: Every other payload byte is emitted once, unchanged, in input order.
- R7: In the cycle after a payload beat is accepted that carries 0x7E, 0x7D or `in_eof`=1, `in_ready` is 0.
- R8: A beat with `in_sof`=1, `in_eof`=1 and `in_empty`=1 produces exactly two consecutive 0x7E bytes.
- R9: While `out_valid` is 1 and `out_ready` is 0, on the next cycle `out_valid` stays 1 and `out_data` is unchanged.
- R10: A beat with `in_empty`=1 and neither marker set produces no output byte.
- R11: With `out_ready` held high, a run of plain payload bytes in mid-frame is accepted at one byte per cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | Beat opens a frame |
| in_eof | input | 1 | Beat closes a frame |
| in_empty | input | 1 | Beat carries no payload byte, only markers |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream takes the byte when high with out_valid |
| out_data | output | 8 | Encoded output byte |

## Verification
The output register can drain the last pending item in the same cycle that a new beat is loaded into the pending list. The block can also hold a stalled output byte while it refuses input. The bench provokes both by toggling `out_ready` with a pseudo-random pattern while frames with escapes at the start, middle and end arrive back to back. A scoreboard judges the result, comparing every handed-over byte with the expected stuffed sequence. Separate checks confirm that a stalled byte holds and that no byte is lost or doubled when a load and a drain fall in the same cycle.

// File: rtl/bstuff_pkg.sv
package bstuff_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              out_valid;
        logic [BYTE_W-1:0] out_data;
        logic              need_sof;
        logic [1:0]        body_cnt;
        logic [BYTE_W-1:0] body_byte;
        logic              need_eof;
    } enc_state_t;
endpackage

// File: rtl/bstuff_classify.sv
module bstuff_classify #(
    parameter int          W    = 8,
    parameter logic [W-1:0] FLAG = 8'h7E,
    parameter logic [W-1:0] ESC  = 8'h7D,
    parameter logic [W-1:0] FLIP = 8'h20
) (
    input  logic [W-1:0] byte_i,
    input  logic         empty_i,
    output logic [1:0]   cnt_o,
    output logic [W-1:0] byte_o
);
    always_comb begin
        cnt_o  = 2'd1;
        byte_o = byte_i;
        if (empty_i) begin
            cnt_o = 2'd0;
        end else if (byte_i == FLAG || byte_i == ESC) begin
            cnt_o  = 2'd2;
            byte_o = byte_i ^ FLIP;
        end
    end
endmodule

// File: rtl/bstuff_pick.sv
module bstuff_pick #(
    parameter int          W    = 8,
    parameter logic [W-1:0] FLAG = 8'h7E,
    parameter logic [W-1:0] ESC  = 8'h7D
) (
    input  logic         sof_i,
    input  logic [1:0]   cnt_i,
    input  logic [W-1:0] byte_i,
    input  logic         eof_i,
    output logic         has_o,
    output logic [W-1:0] item_o,
    output logic         sof_o,
    output logic [1:0]   cnt_o,
    output logic         eof_o
);
    always_comb begin
        has_o  = 1'b1;
        item_o = FLAG;
        sof_o  = sof_i;
        cnt_o  = cnt_i;
        eof_o  = eof_i;
        if (sof_i) begin
            sof_o = 1'b0;
        end else if (cnt_i == 2'd2) begin
            item_o = ESC;
            cnt_o  = 2'd1;
        end else if (cnt_i == 2'd1) begin
            item_o = byte_i;
            cnt_o  = 2'd0;
        end else if (eof_i) begin
            eof_o = 1'b0;
        end else begin
            has_o = 1'b0;
        end
    end
endmodule

// File: rtl/bstuff_encoder.sv
module bstuff_encoder
    import bstuff_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FLAG = 8'h7E,
    parameter logic [BYTE_W-1:0] ESC  = 8'h7D,
    parameter logic [BYTE_W-1:0] FLIP = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_empty,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data
);
    enc_state_t st_q, st_d;

    logic [1:0]        cls_cnt;
    logic [BYTE_W-1:0] cls_byte;
    logic              pk_has, pk_sof, pk_eof;
    logic [1:0]        pk_cnt;
    logic [BYTE_W-1:0] pk_item;
    logic [2:0]        pend_cnt;
    logic              out_free;

    bstuff_classify #(.W(BYTE_W), .FLAG(FLAG), .ESC(ESC), .FLIP(FLIP)) u_cls (
        .byte_i (in_data),
        .empty_i(in_empty),
        .cnt_o  (cls_cnt),
        .byte_o (cls_byte)
    );

    bstuff_pick #(.W(BYTE_W), .FLAG(FLAG), .ESC(ESC)) u_pick (
        .sof_i (st_q.need_sof),
        .cnt_i (st_q.body_cnt),
        .byte_i(st_q.body_byte),
        .eof_i (st_q.need_eof),
        .has_o (pk_has),
        .item_o(pk_item),
        .sof_o (pk_sof),
        .cnt_o (pk_cnt),
        .eof_o (pk_eof)
    );

    assign pend_cnt  = {2'b00, st_q.need_sof} + {1'b0, st_q.body_cnt} + {2'b00, st_q.need_eof};
    assign out_free  = !st_q.out_valid || out_ready;
    assign in_ready  = (pend_cnt == 3'd0) || (out_free && pend_cnt == 3'd1);
    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;

    always_comb begin
        st_d = st_q;
        if (out_free) begin
            st_d.out_valid = pk_has;
            if (pk_has) begin
                st_d.out_data = pk_item;
            end
            st_d.need_sof = pk_sof;
            st_d.body_cnt = pk_cnt;
            st_d.need_eof = pk_eof;
        end
        if (in_valid && in_ready) begin
            st_d.need_sof  = in_sof;
            st_d.body_cnt  = cls_cnt;
            st_d.body_byte = cls_byte;
            st_d.need_eof  = in_eof;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bstuff_encoder_chk.sv
module bstuff_encoder_chk #(
    parameter logic [7:0] FLAG = 8'h7E,
    parameter logic [7:0] ESC  = 8'h7D,
    parameter logic [7:0] FLIP = 8'h20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       in_eof,
    input logic       in_empty,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r4_r5_escape_pair: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_data == ESC |=>
            out_valid && (out_data == (FLAG ^ FLIP) || out_data == (ESC ^ FLIP)));

    a_r7_stall_after_escape: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_empty && (in_data == FLAG || in_data == ESC) |=> !in_ready);

    a_r7_stall_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_empty && in_eof |=> !in_ready);
endmodule

bind bstuff_encoder bstuff_encoder_chk #(.FLAG(FLAG), .ESC(ESC), .FLIP(FLIP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_eof   (in_eof),
    .in_empty (in_empty),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/bstuff_encoder_bench.sv
module bstuff_encoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_empty = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    int         last_stalls = 0;
    int         got_bytes = 0;

    always #5 clk = ~clk;

    bstuff_encoder u_bstuff_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_empty(in_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic send(input logic [7:0] b, input bit sof, input bit eof, input bit emp);
        int stalls;
        if (sof) push(8'h7E, "R2");
        if (!emp) begin
            if (b == 8'h7E) begin push(8'h7D, "R4"); push(8'h5E, "R4"); end
            else if (b == 8'h7D) begin push(8'h7D, "R5"); push(8'h5D, "R5"); end
            else push(b, "R6");
        end
        if (eof) push(8'h7E, "R3");
        in_valid = 1'b1; in_data = b; in_sof = sof; in_eof = eof; in_empty = emp;
        stalls = 0;
        #2;
        while (!in_ready) begin
            @(negedge clk); #2;
            stalls++;
        end
        last_stalls = stalls;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_empty = 1'b0;
        if (!emp && (eof || b == 8'h7E || b == 8'h7D)) begin
            #2;
            check(in_ready == 1'b0, "R7", in_ready, 0);
        end
    endtask

    // monitor / scoreboard
    initial begin
        bit         stall_prev;
        logic [7:0] prev_data;
        stall_prev = 1'b0;
        prev_data  = 8'h00;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[1]);
            #1;
            if (rst_n) begin
                if (stall_prev) begin
                    check(out_valid && out_data == prev_data, "R9", out_data, prev_data);
                end
                if (out_valid && out_ready) begin
                    got_bytes++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10", out_data, 0);
                    end else begin
                        logic [7:0] e;
                        string      t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_data == e, t, out_data, e);
                    end
                end
                stall_prev = out_valid && !out_ready;
                prev_data  = out_data;
            end else begin
                stall_prev = 1'b0;
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);

        // mixed frame under random backpressure
        rdy_mode = 1;
        @(negedge clk);
        send(8'h11, 1, 0, 0);
        send(8'h7E, 0, 0, 0);
        send(8'h22, 0, 0, 0);
        send(8'h7D, 0, 0, 0);
        send(8'h33, 0, 1, 0);
        // single escaped byte as a whole frame
        send(8'h7E, 1, 1, 0);
        // empty frame (R8)
        send(8'h00, 1, 1, 1);
        // ignored marker-less empty beat (R10), then a frame
        send(8'h7D, 0, 0, 1);
        send(8'h7D, 1, 1, 0);
        // escapes back to back
        send(8'h7E, 1, 0, 0);
        send(8'h7E, 0, 0, 0);
        send(8'h7D, 0, 1, 0);
        drain();
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);

        // empty frame alone, with count of bytes (R8)
        got_bytes = 0;
        send(8'h00, 1, 1, 1);
        drain();
        check(got_bytes == 2, "R8", got_bytes, 2);

        // marker-less empty beat alone yields nothing (R10)
        got_bytes = 0;
        send(8'h55, 0, 0, 1);
        drain();
        check(got_bytes == 0, "R10", got_bytes, 0);

        // sustained throughput (R11)
        rdy_mode = 0;
        @(negedge clk);
        send(8'h01, 1, 0, 0);
        send(8'h02, 0, 0, 0);
        for (int k = 3; k < 8; k++) begin
            send(8'(k), 0, 0, 0);
            check(last_stalls == 0, "R11", last_stalls, 0);
        end
        send(8'h08, 0, 1, 0);
        drain();
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule